// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

This block gathers interrupt requests from six sources and turns them into one processor interrupt priority level (0 to 7) and the matching autovector number. The six sources are two peripheral I/O controllers, an Ethernet controller, a serial controller, a sound controller and a non-maskable source. A single mode pin chooses between two routing maps.

In classic mode the Ethernet and sound requests get no CPU level. They go out on two forwarding lines that feed the secondary I/O controller. The sound line is inverted on the way, so the secondary controller sees a falling edge when sound asserts. In separate-levels mode every source has a CPU level of its own, and both forwarding lines stay low.

The non-maskable source does not come in as a level. A one-cycle trigger starts a hold counter, and the counter keeps a level-7 request active for a parameterised number of clock cycles.

Top module: `irq_prio_router`

## Requirements
- R1: With `mode_i` = 1 (classic), the first I/O controller requests level 1, the second I/O controller level 2, the serial controller level 4 and an active NMI hold level 7.
- R2: In classic mode the Ethernet request raises no level. `fwd_eth_o` follows `irq_eth_i` unchanged.
- R3: In classic mode the sound request raises no level. `fwd_snd_o` equals the inverse of `irq_snd_i`.
- R4: With `mode_i` = 0 (separate levels), Ethernet requests level 3, sound level 5, the first I/O controller level 6, the second I/O controller level 2, serial level 4 and an active NMI hold level 7.
- R5: In separate-levels mode both `fwd_eth_o` and `fwd_snd_o` are 0.
- R6: Pending requests are held as a bit set in which bit i stands for level i+1. `ipl_o` is the highest requested level, and 0 when nothing is requested.
- R7: `vector_o` is 24 + `ipl_o` when `ipl_o` is not 0, which gives 25 to 31, and 0 when `ipl_o` is 0.
- R8: A one-cycle pulse on `nmi_trig_i` makes the level-7 request active for exactly HOLD_CYCLES cycles. After that the request drops by itself.
- R9: A trigger that arrives while a hold is running restarts the count at HOLD_CYCLES.
- R10: While `rst_ni` is low, `ipl_o`, `vector_o`, `fwd_eth_o` and `fwd_snd_o` are 0, and any running NMI hold is cancelled.
- R11: Any change of a request input or of `mode_i` reaches `ipl_o`, `vector_o` and the forwarding outputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Routing map select: 1 = classic, 0 = separate levels |
| irq_io1_i | input | 1 | First I/O controller request, level sensitive |
| irq_io2_i | input | 1 | Second I/O controller request, level sensitive |
| irq_eth_i | input | 1 | Ethernet request, level sensitive |
| irq_ser_i | input | 1 | Serial controller request, level sensitive |
| irq_snd_i | input | 1 | Sound request, level sensitive |
| nmi_trig_i | input | 1 | One-cycle pulse that starts or restarts the NMI hold |
| ipl_o | output | 3 | Processor interrupt priority level |
| vector_o | output | 8 | Autovector number, 0 when no request |
| fwd_eth_o | output | 1 | Ethernet request forwarded to the secondary controller (classic mode) |
| fwd_snd_o | output | 1 | Inverted sound request forwarded to the secondary controller (classic mode) |

## Verification
The in-line assertions check these on every cycle:
- the forwarding lines stay quiet after a cycle in separate-levels mode;
- an active NMI hold forces level 7 on the next edge;
- the vector follows the level;
- an empty pending set gives level 0;
- the hold counter steps down by one and releases.

Other behaviour only the bench scenarios can show. This covers the full source-to-level map in each mode and the priority among several requests raised at once. It also covers the exact length of the NMI hold, its restart on a second trigger, and its cancellation by reset. The bench checks all of these against a cycle-level reference model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int unsigned NUM_SRC = 6;

   typedef enum logic [2:0] {
      SRC_IO1 = 3'd0,
      SRC_IO2 = 3'd1,
      SRC_ETH = 3'd2,
      SRC_SER = 3'd3,
      SRC_SND = 3'd4,
      SRC_NMI = 3'd5
   } irq_src_e;

   typedef enum logic {
      MODE_SEPARATE = 1'b0,
      MODE_CLASSIC  = 1'b1
   } route_mode_e;

   // Level a source asks for under a given map; 0 means "not encoded".
   function automatic int unsigned src_level(route_mode_e m, int unsigned s);
      int unsigned lvl;
      lvl = 0;
      if (m == MODE_CLASSIC) begin
         case (s)
            32'(SRC_IO1): lvl = 1;
            32'(SRC_IO2): lvl = 2;
            32'(SRC_SER): lvl = 4;
            32'(SRC_NMI): lvl = 7;
            default:      lvl = 0;
         endcase
      end else begin
         case (s)
            32'(SRC_IO1): lvl = 6;
            32'(SRC_IO2): lvl = 2;
            32'(SRC_ETH): lvl = 3;
            32'(SRC_SER): lvl = 4;
            32'(SRC_SND): lvl = 5;
            32'(SRC_NMI): lvl = 7;
            default:      lvl = 0;
         endcase
      end
      return lvl;
   endfunction

endpackage

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
   parameter int unsigned HOLD_CYCLES = 12_500_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   output logic active_o
);
   localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_CYCLES);

   initial begin
      if (HOLD_CYCLES < 1) $error("irq_nmi_stretch: HOLD_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (trig_i)         cnt_q <= HOLD_VAL;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   // R9: a trigger always (re)loads the full hold time
   a_r9_restart_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_i |=> (cnt_q == HOLD_VAL));
   // R8: hold runs down one per cycle and releases at the end
   a_r8_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o && !trig_i && cnt_q != 1) |=> active_o);
   a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == 1 && !trig_i) |=> !active_o);
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
   import irq_router_pkg::*;
#(
   parameter int unsigned PEND_W = 8
) (
   input  logic               mode_i,
   input  logic [NUM_SRC-1:0] req_i,
   output logic [PEND_W-1:0]  pend_d_o,
   output logic               fwd_eth_o,
   output logic               fwd_snd_o
);
   initial begin
      if (PEND_W < 7) $error("irq_level_map: PEND_W must cover levels 1..7");
   end

   logic [PEND_W-1:0] contrib [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int unsigned L_CL = src_level(MODE_CLASSIC,  s);
      localparam int unsigned L_SP = src_level(MODE_SEPARATE, s);
      always_comb begin
         contrib[s] = '0;
         if (mode_i == MODE_CLASSIC) begin
            if (L_CL != 0) contrib[s][L_CL-1] = req_i[s];
         end else begin
            if (L_SP != 0) contrib[s][L_SP-1] = req_i[s];
         end
      end
   end

   always_comb begin
      pend_d_o = '0;
      for (int s = 0; s < NUM_SRC; s++) pend_d_o = pend_d_o | contrib[s];
   end

   assign fwd_eth_o = (mode_i == MODE_CLASSIC) &  req_i[SRC_ETH];
   assign fwd_snd_o = (mode_i == MODE_CLASSIC) & ~req_i[SRC_SND];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned PEND_W = 8,
   parameter int unsigned LVL_W  = 3
) (
   input  logic [PEND_W-1:0] pend_i,
   output logic [LVL_W-1:0]  lvl_o
);
   localparam int unsigned MAX_LVL = (1 << LVL_W) - 1;
   localparam int unsigned SCAN    = (PEND_W < MAX_LVL) ? PEND_W : MAX_LVL;

   initial begin
      if (LVL_W < 1) $error("irq_prio_enc: LVL_W must be at least 1");
   end

   // ascending scan: the last (highest) set bit wins
   always_comb begin
      lvl_o = '0;
      for (int i = 0; i < SCAN; i++) begin
         if (pend_i[i]) lvl_o = LVL_W'(i + 1);
      end
   end
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
   import irq_router_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 12_500_000,
   parameter int unsigned PEND_W      = 8,
   parameter int unsigned LVL_W       = 3,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned VEC_BASE    = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mode_i,
   input  logic             irq_io1_i,
   input  logic             irq_io2_i,
   input  logic             irq_eth_i,
   input  logic             irq_ser_i,
   input  logic             irq_snd_i,
   input  logic             nmi_trig_i,
   output logic [LVL_W-1:0] ipl_o,
   output logic [VEC_W-1:0] vector_o,
   output logic             fwd_eth_o,
   output logic             fwd_snd_o
);
   localparam int unsigned MAX_LVL = (1 << LVL_W) - 1;

   initial begin
      if (VEC_BASE + MAX_LVL >= (1 << VEC_W))
         $error("irq_prio_router: vector range does not fit VEC_W");
      if (LVL_W != 3) $error("irq_prio_router: level map assumes 3-bit levels");
   end

   logic               nmi_act;
   logic [NUM_SRC-1:0] req;
   logic [PEND_W-1:0]  pend_d, pend_q;
   logic               fwd_eth_d, fwd_snd_d;

   irq_nmi_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_nmi (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (nmi_trig_i),
      .active_o (nmi_act)
   );

   always_comb begin
      req          = '0;
      req[SRC_IO1] = irq_io1_i;
      req[SRC_IO2] = irq_io2_i;
      req[SRC_ETH] = irq_eth_i;
      req[SRC_SER] = irq_ser_i;
      req[SRC_SND] = irq_snd_i;
      req[SRC_NMI] = nmi_act;
   end

   irq_level_map #(.PEND_W(PEND_W)) u_map (
      .mode_i    (mode_i),
      .req_i     (req),
      .pend_d_o  (pend_d),
      .fwd_eth_o (fwd_eth_d),
      .fwd_snd_o (fwd_snd_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q    <= '0;
         fwd_eth_o <= 1'b0;
         fwd_snd_o <= 1'b0;
      end else begin
         pend_q    <= pend_d;
         fwd_eth_o <= fwd_eth_d;
         fwd_snd_o <= fwd_snd_d;
      end
   end

   irq_prio_enc #(.PEND_W(PEND_W), .LVL_W(LVL_W)) u_enc (
      .pend_i (pend_q),
      .lvl_o  (ipl_o)
   );

   assign vector_o = (ipl_o == '0) ? '0 : VEC_W'(VEC_BASE) + VEC_W'(ipl_o);

   // R5: separate-levels mode keeps the forwarding lines low
   a_r5_fwd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_SEPARATE) |=> (!fwd_eth_o && !fwd_snd_o));
   // R1/R4: an active NMI hold wins with the top level one edge later
   a_r4_nmi_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_act |=> (ipl_o == LVL_W'(7)));
   // R7: vector tracks level
   a_r7_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ipl_o != '0) |-> (vector_o == VEC_W'(VEC_BASE + 32'(ipl_o))));
   // R6: empty pending set encodes to level 0
   a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q == '0) |-> (ipl_o == '0 && vector_o == '0));
endmodule

// File: tb/tb_irq_prio_router.sv
`timescale 1ns/1ps
module tb_irq_prio_router;
   localparam int HOLD = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 1'b1, io1 = 0, io2 = 0, eth = 0, ser = 0, snd = 0, trig = 0;
   logic [2:0] ipl;
   logic [7:0] vec;
   logic f_eth, f_snd;

   always #4 clk = ~clk;   // 125 MHz

   irq_prio_router #(.HOLD_CYCLES(HOLD)) dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
      .irq_io1_i(io1), .irq_io2_i(io2), .irq_eth_i(eth), .irq_ser_i(ser),
      .irq_snd_i(snd), .nmi_trig_i(trig),
      .ipl_o(ipl), .vector_o(vec), .fwd_eth_o(f_eth), .fwd_snd_o(f_snd)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   string tag = "R10";

   // behavioural reference
   int m_cnt = 0, m_lvl = 0, m_vec = 0;
   bit m_feth = 0, m_fsnd = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_lvl = 0; m_vec = 0; m_feth = 0; m_fsnd = 0;
      end else begin
         int req_lv[$];
         req_lv = {};
         if (mode) begin
            if (io1) req_lv.push_back(1);
            if (io2) req_lv.push_back(2);
            if (ser) req_lv.push_back(4);
            if (m_cnt > 0) req_lv.push_back(7);
            m_feth = eth; m_fsnd = !snd;
         end else begin
            if (io1) req_lv.push_back(6);
            if (io2) req_lv.push_back(2);
            if (eth) req_lv.push_back(3);
            if (ser) req_lv.push_back(4);
            if (snd) req_lv.push_back(5);
            if (m_cnt > 0) req_lv.push_back(7);
            m_feth = 0; m_fsnd = 0;
         end
         m_lvl = 0;
         foreach (req_lv[k]) if (req_lv[k] > m_lvl) m_lvl = req_lv[k];
         m_vec = (m_lvl == 0) ? 0 : 24 + m_lvl;
         if (trig) m_cnt = HOLD;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // compare against model, away from the active edge
   task automatic cmp_model();
      chk({tag, " level"},  int'(ipl),   m_lvl);
      chk("R7 vector",       int'(vec),   m_vec);
      chk({tag, " fwd_eth"}, int'(f_eth), int'(m_feth));
      chk({tag, " fwd_snd"}, int'(f_snd), int'(m_fsnd));
   endtask

   task automatic step();
      @(negedge clk);
      cmp_model();
   endtask

   task automatic set_src(bit a, bit b, bit e, bit s, bit d);
      io1 = a; io2 = b; eth = e; ser = s; snd = d;
   endtask

   initial begin
      #(8 * 50000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      end
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 ipl", int'(ipl), 0); chk("R10 vec", int'(vec), 0);
      chk("R10 fwd_eth", int'(f_eth), 0); chk("R10 fwd_snd", int'(f_snd), 0);
      rst_n = 1;

      // R1 classic map, single sources; R11 one-edge latency
      tag = "R1"; mode = 1;
      set_src(1,0,0,0,0); step();
      chk("R11 latency", int'(ipl), 1); step(); chk("R1 io1", int'(ipl), 1);
      chk("R7 vec25", int'(vec), 25);
      set_src(0,1,0,0,0); step(); step(); chk("R1 io2", int'(ipl), 2);
      set_src(0,0,0,1,0); step(); step(); chk("R1 ser", int'(ipl), 4);
      chk("R3 fwd_snd inverted", int'(f_snd), 1);
      // R2 / R3 forwarding in classic
      tag = "R2"; set_src(0,0,1,0,0); step(); step();
      chk("R2 eth no level", int'(ipl), 0); chk("R2 fwd_eth", int'(f_eth), 1);
      chk("R7 vec0", int'(vec), 0);
      tag = "R3"; set_src(0,0,0,0,1); step(); step();
      chk("R3 snd no level", int'(ipl), 0); chk("R3 fwd_snd low", int'(f_snd), 0);
      // R6 priority among several
      tag = "R6"; set_src(1,1,0,1,0); step(); step(); chk("R6 highest", int'(ipl), 4);

      // R4 separate-levels map; R5 forwarding quiet
      tag = "R4"; mode = 0;
      set_src(1,0,0,0,0); step(); step(); chk("R4 io1", int'(ipl), 6);
      chk("R5 fwd_snd", int'(f_snd), 0);
      set_src(0,0,1,0,0); step(); step(); chk("R4 eth", int'(ipl), 3);
      chk("R5 fwd_eth", int'(f_eth), 0);
      set_src(0,0,0,0,1); step(); step(); chk("R4 snd", int'(ipl), 5);
      set_src(0,1,1,1,1); step(); step(); chk("R4 mix", int'(ipl), 5);
      chk("R7 vec29", int'(vec), 29);
      // R11 mode change alone
      tag = "R11"; set_src(1,0,0,0,0); step(); mode = 1; step(); chk("R11 mode", int'(ipl), 1);
      set_src(0,0,0,0,0); step();

      // R8 NMI hold length
      tag = "R8"; mode = 1;
      @(negedge clk); trig = 1; @(negedge clk); cmp_model(); trig = 0;
      for (int i = 0; i < HOLD + 3; i++) begin
         step();
         if (i < HOLD) chk("R8 held", int'(ipl), 7);
         if (i == HOLD + 1) chk("R8 released", int'(ipl), 0);
      end
      // R9 retrigger mid-hold
      tag = "R9";
      trig = 1; step(); trig = 0;
      repeat (HOLD / 2) step();
      trig = 1; step(); trig = 0;
      for (int i = 0; i < HOLD + 2; i++) begin
         step();
         if (i == HOLD - 2) chk("R9 still held", int'(ipl), 7);
      end
      chk("R9 released", int'(ipl), 0);

      // R10 reset cancels hold
      tag = "R10";
      trig = 1; step(); trig = 0; step(); step();
      rst_n = 0; #1; chk("R10 async clear", int'(ipl), 0);
      @(negedge clk); rst_n = 1;
      repeat (3) begin step(); chk("R10 hold cancelled", int'(ipl), 0); end

      // pseudo-random patterns in both modes
      tag = "R6"; lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         set_src(lfsr[0], lfsr[1], lfsr[2], lfsr[3], lfsr[4]);
         mode = (i < 300) ? lfsr[5] | lfsr[6] : lfsr[5] & lfsr[6];
         trig = (lfsr[15:10] == 6'h2A);
         step();
      end
      trig = 0;

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      end
      $finish;
   end
endmodule